// File: doc/BRIEF.md
# Integer ALU with Zero and Overflow Flags

A purely combinational integer arithmetic and logic unit for a simple load/store datapath. Two operands and a four-bit operation code go in. A result word, a zero flag and a signed-overflow flag come out in the same cycle. The unit covers signed and unsigned addition and subtraction, four bitwise functions, and signed and unsigned set-on-less-than. Immediates are expected to be sign- or zero-extended before they reach the operand port.

Subtraction, both less-than comparisons and equality testing all use one shared adder. For these operations the second operand is inverted and the carry-in is forced high. Equality is tested by subtracting and looking at the zero flag. The adder is a parameterised library piece that can be built as a bit-serial ripple chain or as grouped carry lookahead, and the group size is also a parameter.

Top module: `int_alu`

## Requirements
- R1: Op codes 0x0 (signed add) and 0x1 (unsigned add) return (A + B) modulo 2^WIDTH.
- R2: Op codes 0x2 (signed subtract) and 0x3 (unsigned subtract) return (A - B) modulo 2^WIDTH.
- R3: For op 0x0 and op 0x2, `ovf` is 1 exactly when the true two's-complement sum or difference falls outside the signed WIDTH-bit range. This is the carry into the top bit XOR the carry out of it.
- R4: For op codes 0x1, 0x3, 0xB and 0x4–0x7, `ovf` is 0.
- R5: Op 0x4 returns A AND B, op 0x5 returns A OR B, op 0x6 returns A XOR B and op 0x7 returns NOT (A OR B).
- R6: Op 0xA returns 1 in bit 0 when A < B as signed numbers, and 0 otherwise. This holds even when the internal subtraction overflows. All higher bits are 0.
- R7: Op 0xB returns 1 in bit 0 when A < B as unsigned numbers, and 0 otherwise. All higher bits are 0.
- R8: `zero` is 1 exactly when every result bit is 0. In particular, subtracting equal operands raises it.
- R9: Op codes 0x8, 0x9 and 0xC–0xF return a zero result with `ovf` cleared.
- R10: A ripple-carry build of the unit at another width meets R1–R9 for that width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand (subtrahend for subtract and compare) |
| op_sel | input | 4 | Operation code |
| result | output | WIDTH | Operation result |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow, for signed add and subtract only |

## Verification
The bench builds two copies of the unit. The first uses the default 32-bit width with four-bit lookahead groups. The second is 8 bits wide with the ripple adder, so the carry-chain variant and a narrow width are both exercised. The 8-bit copy makes the signed and unsigned boundaries (0x7F, 0x80, 0xFF) easy to reach with random operands. Directed vectors drive both copies across the most-negative and most-positive values, where subtraction overflows and the signed comparison must fold the overflow back in.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'h0,
      OP_ADDU = 4'h1,
      OP_SUB  = 4'h2,
      OP_SUBU = 4'h3,
      OP_AND  = 4'h4,
      OP_OR   = 4'h5,
      OP_XOR  = 4'h6,
      OP_NOR  = 4'h7,
      OP_SLT  = 4'hA,
      OP_SLTU = 4'hB
   } alu_op_e;

   typedef enum int {
      ADDER_RIPPLE    = 0,
      ADDER_LOOKAHEAD = 1
   } adder_style_e;

endpackage

// File: rtl/int_alu_adder.sv
module int_alu_adder
   import int_alu_pkg::*;
#(
   parameter int           WIDTH = 32,
   parameter int           GRP   = 4,
   parameter adder_style_e STYLE = ADDER_LOOKAHEAD
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             c_msb,
   output logic             c_out
);

   localparam int NGRP = WIDTH / GRP;

   logic [WIDTH-1:0] gen, prp, hlf;
   logic [WIDTH:0]   cy;

   assign gen   = a & b;
   assign prp   = a | b;
   assign hlf   = a ^ b;
   assign cy[0] = cin;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu_adder: WIDTH must be at least 2");
      end
      if (STYLE == ADDER_LOOKAHEAD) begin : g_lookahead
         if (GRP < 2 || (WIDTH % GRP) != 0) begin : g_bad_grp
            $error("int_alu_adder: GRP must be >= 2 and divide WIDTH");
         end
         logic [NGRP:0] cg;
         assign cg[0] = cin;
         for (genvar k = 0; k < NGRP; k++) begin : g_grp
            logic           grp_g, grp_p;
            logic [GRP-2:0] lc;
            always_comb begin
               grp_g = 1'b0;
               grp_p = 1'b1;
               for (int j = 0; j < GRP; j++) begin
                  grp_g = gen[k*GRP+j] | (prp[k*GRP+j] & grp_g);
                  grp_p = grp_p & prp[k*GRP+j];
               end
            end
            always_comb begin
               logic run;
               run = cg[k];
               for (int j = 0; j < GRP-1; j++) begin
                  run   = gen[k*GRP+j] | (prp[k*GRP+j] & run);
                  lc[j] = run;
               end
            end
            assign cg[k+1]                 = grp_g | (grp_p & cg[k]);
            assign cy[k*GRP+1 +: GRP-1]    = lc;
            assign cy[(k+1)*GRP]           = cg[k+1];
         end
      end else begin : g_ripple
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign cy[i+1] = gen[i] | (prp[i] & cy[i]);
         end
      end
   endgenerate

   assign sum   = hlf ^ cy[WIDTH-1:0];
   assign c_msb = cy[WIDTH-1];
   assign c_out = cy[WIDTH];

   // R1/R2: carry chain agrees with arithmetic addition of the same inputs
   always_comb begin
      p_sum_exact_r1: assert ({c_out, sum} ==
                              ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
         else $error("adder sum/carry disagree with arithmetic sum");
   end

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       fn,
   output logic [WIDTH-1:0] y
);

   always_comb begin
      case (fn)
         2'd0:    y = a & b;
         2'd1:    y = a | b;
         2'd2:    y = a ^ b;
         default: y = ~(a | b);
      endcase
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int           WIDTH = 32,
   parameter int           GRP   = 4,
   parameter adder_style_e STYLE = ADDER_LOOKAHEAD
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [OP_W-1:0]  op_sel,
   output logic [WIDTH-1:0] result,
   output logic             zero,
   output logic             ovf
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("int_alu: WIDTH must be at least 2");
      end
   endgenerate

   logic             sub_mode;
   logic [WIDTH-1:0] b_eff, add_sum, logic_y;
   logic             c_msb, c_out, signed_ovf, lt_signed, lt_unsigned;

   always_comb begin
      case (op_sel)
         OP_SUB, OP_SUBU, OP_SLT, OP_SLTU: sub_mode = 1'b1;
         default:                          sub_mode = 1'b0;
      endcase
   end

   assign b_eff = sub_mode ? ~opb : opb;

   int_alu_adder #(.WIDTH(WIDTH), .GRP(GRP), .STYLE(STYLE)) u_adder (
      .a     (opa),
      .b     (b_eff),
      .cin   (sub_mode),
      .sum   (add_sum),
      .c_msb (c_msb),
      .c_out (c_out)
   );

   int_alu_logic #(.WIDTH(WIDTH)) u_logic (
      .a  (opa),
      .b  (opb),
      .fn (op_sel[1:0]),
      .y  (logic_y)
   );

   assign signed_ovf  = c_msb ^ c_out;
   assign lt_signed   = add_sum[MSB] ^ signed_ovf;
   assign lt_unsigned = ~c_out;

   always_comb begin
      result = '0;
      ovf    = 1'b0;
      case (op_sel)
         OP_ADD, OP_SUB: begin
            result = add_sum;
            ovf    = signed_ovf;
         end
         OP_ADDU, OP_SUBU:             result = add_sum;
         OP_AND, OP_OR, OP_XOR, OP_NOR: result = logic_y;
         OP_SLT:                       result[0] = lt_signed;
         OP_SLTU:                      result[0] = lt_unsigned;
         default: ;
      endcase
   end

   assign zero = ~|result;

   always_comb begin
      if (op_sel == OP_ADD)
         p_add_ovf_sign_r3: assert (ovf == ((opa[MSB] == opb[MSB]) &&
                                            (result[MSB] != opa[MSB])))
            else $error("add overflow flag wrong");
      if (op_sel == OP_SUB)
         p_sub_ovf_sign_r3: assert (ovf == ((opa[MSB] != opb[MSB]) &&
                                            (result[MSB] != opa[MSB])))
            else $error("sub overflow flag wrong");
      if (op_sel inside {OP_ADDU, OP_SUBU, OP_SLTU, OP_AND, OP_OR, OP_XOR, OP_NOR})
         p_no_overflow_r4: assert (!ovf)
            else $error("overflow raised on a non-signed op");
      if (op_sel inside {OP_SLT, OP_SLTU})
         p_set_upper_clear_r6: assert (result[MSB:1] == '0)
            else $error("set-on-less-than upper bits not clear");
      if (op_sel inside {OP_SUB, OP_SUBU} && opa == opb)
         p_equal_gives_zero_r8: assert (zero)
            else $error("equal operands did not raise zero");
      if (op_sel inside {4'h8, 4'h9, 4'hC, 4'hD, 4'hE, 4'hF})
         p_undefined_quiet_r9: assert (result == '0 && !ovf)
            else $error("undefined op code produced output");
   end

endmodule

// File: tb/int_alu_test.sv
module int_alu_test;
   import int_alu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [3:0]  op = '0;
   logic [31:0] res32;
   logic [7:0]  res8;
   logic        z32, v32, z8, v8;
   int          n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   int_alu #(.WIDTH(32), .GRP(4), .STYLE(ADDER_LOOKAHEAD)) uut (
      .opa(a), .opb(b), .op_sel(op), .result(res32), .zero(z32), .ovf(v32));

   int_alu #(.WIDTH(8), .GRP(2), .STYLE(ADDER_RIPPLE)) uut_rip (
      .opa(a[7:0]), .opb(b[7:0]), .op_sel(op), .result(res8), .zero(z8), .ovf(v8));

   typedef struct {
      logic [3:0]  op;
      logic [31:0] r32;
      logic        z32, v32;
      logic [31:0] r8;
      logic        z8, v8;
   } exp_t;

   exp_t sb_q[$];

   // reference computed from the requirement text
   function automatic void ref_alu(input int n, input logic [31:0] ai, bi,
                                   input logic [3:0] o,
                                   output logic [31:0] r, output logic v);
      logic [31:0] m;
      logic [31:0] x, y;
      longint sx, sy, s, mx, mn;
      m  = (n == 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
      x  = ai & m;
      y  = bi & m;
      sx = x[n-1] ? longint'(x) - (longint'(1) << n) : longint'(x);
      sy = y[n-1] ? longint'(y) - (longint'(1) << n) : longint'(y);
      mx = (longint'(1) << (n-1)) - 1;
      mn = -(longint'(1) << (n-1));
      case (o)
         4'h0, 4'h1: r = (x + y) & m;
         4'h2, 4'h3: r = (x - y) & m;
         4'h4:       r = x & y;
         4'h5:       r = x | y;
         4'h6:       r = x ^ y;
         4'h7:       r = ~(x | y) & m;
         4'hA:       r = (sx < sy) ? 32'd1 : 32'd0;
         4'hB:       r = (x < y) ? 32'd1 : 32'd0;
         default:    r = 32'd0;
      endcase
      s = (o == 4'h0) ? sx + sy : sx - sy;
      v = (o == 4'h0 || o == 4'h2) && (s > mx || s < mn);
   endfunction

   function automatic string res_tag(input logic [3:0] o);
      case (o)
         4'h0, 4'h1:             return "R1";
         4'h2, 4'h3:             return "R2";
         4'h4, 4'h5, 4'h6, 4'h7: return "R5";
         4'hA:                   return "R6";
         4'hB:                   return "R7";
         default:                return "R9";
      endcase
   endfunction

   function automatic string ovf_tag(input logic [3:0] o);
      return (o == 4'h0 || o == 4'h2) ? "R3" : "R4";
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // driver: apply a vector and push its expectation
   task automatic drive(input logic [31:0] ai, bi, input logic [3:0] o);
      exp_t e;
      logic [31:0] r;
      logic        v;
      @(posedge clk);
      a  = ai;
      b  = bi;
      op = o;
      e.op = o;
      ref_alu(32, ai, bi, o, r, v);
      e.r32 = r; e.v32 = v; e.z32 = (r == 32'd0);
      ref_alu(8, ai, bi, o, r, v);
      e.r8 = r; e.v8 = v; e.z8 = (r == 32'd0);
      sb_q.push_back(e);
   endtask

   // monitor: compare on the falling edge
   always @(negedge clk) begin
      if (rst_n && sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(res_tag(e.op), "result", res32, e.r32);
         check("R8", "zero", {31'd0, z32}, {31'd0, e.z32});
         check(ovf_tag(e.op), "ovf", {31'd0, v32}, {31'd0, e.v32});
         // R10: the narrow ripple build obeys the same rules
         check({"R10/", res_tag(e.op)}, "result8", {24'd0, res8}, e.r8);
         check("R10/R8", "zero8", {31'd0, z8}, {31'd0, e.z8});
         check({"R10/", ovf_tag(e.op)}, "ovf8", {31'd0, v8}, {31'd0, e.v8});
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 7))
         0:       return 32'h0000_0000;
         1:       return 32'h0000_0001;
         2:       return 32'hFFFF_FFFF;
         3:       return 32'h8000_0000;
         4:       return 32'h7FFF_FFFF;
         5:       return {24'd0, 8'h80};
         6:       return {24'd0, 8'h7F};
         default: return $urandom;
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R8: idle inputs give an all-zero result with zero raised
      drive(32'd0, 32'd0, 4'h0);
      // R1/R3 overflow at the positive edge
      drive(32'h7FFF_FFFF, 32'd1, 4'h0);
      drive(32'h7FFF_FFFF, 32'd1, 4'h1);              // R4 unsigned add
      drive(32'hFFFF_FFFF, 32'd1, 4'h1);
      // R2/R3 subtract overflow
      drive(32'h8000_0000, 32'd1, 4'h2);
      drive(32'h8000_0000, 32'd1, 4'h3);
      drive(32'h1234_5678, 32'h1234_5678, 4'h2);      // R8 equality
      drive(32'h0000_0005, 32'h0000_0007, 4'h3);
      // R6 signed compare across overflow
      drive(32'h8000_0000, 32'd1, 4'hA);
      drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 4'hA);
      drive(32'hFFFF_FFFF, 32'h0000_0000, 4'hA);
      drive(32'h0000_0003, 32'h0000_0003, 4'hA);
      // R7 unsigned compare
      drive(32'h0000_0000, 32'hFFFF_FFFF, 4'hB);
      drive(32'hFFFF_FFFF, 32'h0000_0000, 4'hB);
      // R5 bitwise
      drive(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'h4);
      drive(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'h5);
      drive(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'h6);
      drive(32'h0000_0000, 32'h0000_0000, 4'h7);
      // R9 undefined codes
      for (int k = 0; k < 16; k++)
         if (k == 8 || k == 9 || k >= 12)
            drive(32'hFFFF_FFFF, 32'h8000_0000, 4'(k));
      // mixed random traffic over every code
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] ra, rb;
         ra = pick();
         rb = ($urandom_range(0, 9) == 0) ? ra : pick();
         drive(ra, rb, 4'($urandom_range(0, 15)));
      end
      wait (sb_q.size() == 0);
      @(posedge clk);
      finish_run();
   end

endmodule